// File: doc/BRIEF.md
# Operate-Group Micro-Operation Executor

This block carries out the register-only instructions of a 12-bit accumulator machine. Each bit in the low part of such an instruction turns on one micro-operation, so a single word can combine several of them. The block steps through the enabled micro-operations in a fixed order and spends one clock on each step. Because the order is fixed, combinations act as new instructions: clearing the link and then complementing it sets the link.

Two groups are handled. The first group changes the accumulator and the link with clear, complement, increment and rotate steps. The second group tests the accumulator and the link for a skip decision, can clear the accumulator, can OR a switch value into it, and can raise a halt request. A controller pulses `start` with the instruction and the current register values. It then waits for `done` and takes the new accumulator, link, skip and halt values, which stay stable until the next start.

Bit numbering follows the instruction convention. Bit n is the nth bit counted from the most significant end, so bit n is `instr[11-n]`. The opcode is bits 0 to 2, which is `instr[11:9]`.

Top module: `opx_exec`

## Requirements
- R1: Group 1 is an opcode of 7 with bit 3 (`instr[8]`) clear. Group 2 is an opcode of 7 with bit 3 set and bit 11 (`instr[0]`) clear. Any other word completes in one step with the accumulator and link unchanged and with skip and halt low.
- R2: After reset, `done`, `skip_out`, `halt_out`, `link_out` and `ac_out` are all zero.
- R3: Group 1 step one: bit 4 (`instr[7]`) clears the accumulator and bit 5 (`instr[6]`) clears the link.
- R4: Group 1 step two runs after step one: bit 6 (`instr[5]`) complements the accumulator and bit 7 (`instr[4]`) complements the link. Bits 5,7 at 1,0 clear the link, at 0,1 invert it, and at 1,1 set it.
- R5: Group 1 step three: bit 11 (`instr[0]`) adds one to the accumulator. A carry out of the accumulator inverts the link.
- R6: Group 1 step four rotates the 13-bit value {link, accumulator}. Bit 8 (`instr[3]`) rotates right and bit 9 (`instr[2]`) rotates left. Bit 10 (`instr[1]`) makes the rotate two places. When bits 8 and 9 are both set, the step leaves both registers unchanged.
- R7: Group 2 skip uses the incoming values. Bit 5 (`instr[6]`) tests for a negative accumulator (top bit set), bit 6 (`instr[5]`) for a zero accumulator, and bit 7 (`instr[4]`) for a set link. With bit 8 (`instr[3]`) clear, skip is the OR of the selected tests. With bit 8 set, skip is the complement of that OR.
- R8: In group 2, bit 4 (`instr[7]`) clears the accumulator after the skip test. Bit 9 (`instr[2]`) then ORs `sw_in` into the accumulator.
- R9: `halt_out` goes high together with `done` when the word is group 2 with bit 10 (`instr[1]`) set. Otherwise it is low. It holds until the next start.
- R10: Each enabled step takes one clock. `done` is a one-cycle pulse that comes N clocks after the start edge. N is the number of enabled steps, or 1 if no step is enabled. Group 2 always has the skip step enabled. All outputs hold after `done`.
- R11: A group 2 word never changes the link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Pulse that captures the inputs and begins execution; used only while idle |
| instr | input | 12 | Instruction word |
| ac_in | input | DW | Accumulator value before the instruction |
| link_in | input | 1 | Link value before the instruction |
| sw_in | input | DW | Switch register value |
| ac_out | output | DW | Accumulator result |
| link_out | output | 1 | Link result |
| skip_out | output | 1 | Skip decision |
| halt_out | output | 1 | Halt request |
| done | output | 1 | One-cycle completion strobe |

## Verification
The assertions assume that `start` is only raised while no instruction is in flight. The stimulus meets this by pulsing `start` for one cycle and then waiting for `done` and one further idle cycle. The assertions also assume that the instruction and register inputs matter only on the start cycle, since the block captures them there. The sweeps cover every combination of group 1 control bits and every combination of group 2 bits 4 to 10. They use accumulator values that hit zero, all ones, the sign boundary and a mixed pattern, with both link values.

// File: rtl/opx_pkg.sv
package opx_pkg;

   localparam int IW    = 12;
   localparam int NSTEP = 4;

   typedef enum logic [1:0] {
      GRP_NONE = 2'd0,
      GRP_ONE  = 2'd1,
      GRP_TWO  = 2'd2
   } grp_e;

   // opcode 7 in the top three bits; bit 3 (instr[8]) picks the group,
   // bit 11 (instr[0]) must be clear for group 2
   function automatic grp_e classify(input logic [IW-1:0] ir);
      grp_e g;
      if (ir[11:9] != 3'b111)
         g = GRP_NONE;
      else if (!ir[8])
         g = GRP_ONE;
      else if (!ir[0])
         g = GRP_TWO;
      else
         g = GRP_NONE;
      return g;
   endfunction

endpackage

// File: rtl/opx_pick.sv
module opx_pick #(
   parameter int N = 4
) (
   input  logic [N-1:0] pend,
   output logic [N-1:0] first,
   output logic         last
);

   if (N < 1) begin : g_bad_n
      $error("opx_pick: N must be at least 1");
   end

   logic [N:0] seen;
   assign seen[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_chain
      assign seen[i+1] = seen[i] | pend[i];
      assign first[i]  = pend[i] & ~seen[i];
   end

   assign last = ((pend & ~first) == '0);

endmodule

// File: rtl/opx_g1.sv
module opx_g1 #(
   parameter int DW         = 12,
   parameter bit DOUBLE_ROT = 1'b1
) (
   input  logic [7:0]    ctl,   // instruction bits 4..11 = instr[7:0]
   input  logic [DW-1:0] ac,
   input  logic          lk,
   input  logic [3:0]    slot,  // one-hot active step
   output logic [DW-1:0] ac_nx,
   output logic          lk_nx
);

   if (DW < 2) begin : g_bad_dw
      $error("opx_g1: DW must be at least 2");
   end

   logic twice;
   if (DOUBLE_ROT) begin : g_dbl
      assign twice = ctl[1];          // bit 10
   end else begin : g_sgl
      assign twice = 1'b0;
   end

   logic [DW:0] v, rr1, rr2, rl1, rl2, rot, sum;

   always_comb begin
      v   = {lk, ac};
      rr1 = {v[0], v[DW:1]};
      rr2 = {rr1[0], rr1[DW:1]};
      rl1 = {v[DW-1:0], v[DW]};
      rl2 = {rl1[DW-1:0], rl1[DW]};
      case ({ctl[3], ctl[2]})           // bit 8 right, bit 9 left
         2'b10:   rot = twice ? rr2 : rr1;
         2'b01:   rot = twice ? rl2 : rl1;
         default: rot = v;
      endcase
      sum = {1'b0, ac} + {{DW{1'b0}}, 1'b1};
   end

   always_comb begin
      ac_nx = ac;
      lk_nx = lk;
      if (slot[0]) begin
         if (ctl[7]) ac_nx = '0;        // bit 4
         if (ctl[6]) lk_nx = 1'b0;      // bit 5
      end
      if (slot[1]) begin
         if (ctl[5]) ac_nx = ~ac;       // bit 6
         if (ctl[4]) lk_nx = ~lk;       // bit 7
      end
      if (slot[2]) begin
         ac_nx = sum[DW-1:0];
         lk_nx = lk ^ sum[DW];
      end
      if (slot[3]) begin
         {lk_nx, ac_nx} = rot;
      end
   end

endmodule

// File: rtl/opx_g2.sv
module opx_g2 #(
   parameter int DW = 12
) (
   input  logic [5:0]    fld,   // instruction bits 4..9 = instr[7:2]
   input  logic [DW-1:0] ac,
   input  logic          lk,
   input  logic [DW-1:0] sw,
   input  logic [2:0]    slot,  // test, clear, or-switch
   output logic [DW-1:0] ac_nx,
   output logic          hit
);

   if (DW < 2) begin : g_bad_dw
      $error("opx_g2: DW must be at least 2");
   end

   logic neg, zero, any;

   always_comb begin
      neg  = ac[DW-1];
      zero = (ac == '0);
      any  = (fld[4] & neg) | (fld[3] & zero) | (fld[2] & lk);
      hit  = fld[1] ? ~any : any;
   end

   always_comb begin
      ac_nx = ac;
      if (slot[1] && fld[5]) ac_nx = '0;
      if (slot[2] && fld[0]) ac_nx = ac | sw;
   end

endmodule

// File: rtl/opx_exec.sv
module opx_exec #(
   parameter int DW         = 12,
   parameter bit DOUBLE_ROT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [11:0]   instr,
   input  logic [DW-1:0] ac_in,
   input  logic          link_in,
   input  logic [DW-1:0] sw_in,
   output logic [DW-1:0] ac_out,
   output logic          link_out,
   output logic          skip_out,
   output logic          halt_out,
   output logic          done
);
   import opx_pkg::*;

   localparam int NS = NSTEP;

   if (DW < 2) begin : g_bad_dw
      $error("opx_exec: DW must be at least 2");
   end

   grp_e          grp_in, grp_r;
   logic [NS-1:0] mask_in, pend, first;
   logic          last, busy;
   logic [7:0]    ir_r;
   logic [DW-1:0] ac_r, sw_r, g1_ac, g2_ac;
   logic          lk_r, g1_lk, g2_hit, skip_r, halt_r, done_r;

   assign grp_in = classify(instr);

   always_comb begin
      case (grp_in)
         GRP_ONE: mask_in = {instr[3] | instr[2], instr[0],
                             instr[5] | instr[4], instr[7] | instr[6]};
         GRP_TWO: mask_in = {1'b0, instr[2], instr[7], 1'b1};
         default: mask_in = '0;
      endcase
   end

   opx_pick #(.N(NS)) u_pick (
      .pend  (pend),
      .first (first),
      .last  (last)
   );

   opx_g1 #(.DW(DW), .DOUBLE_ROT(DOUBLE_ROT)) u_g1 (
      .ctl   (ir_r),
      .ac    (ac_r),
      .lk    (lk_r),
      .slot  (first),
      .ac_nx (g1_ac),
      .lk_nx (g1_lk)
   );

   opx_g2 #(.DW(DW)) u_g2 (
      .fld   (ir_r[7:2]),
      .ac    (ac_r),
      .lk    (lk_r),
      .sw    (sw_r),
      .slot  (first[2:0]),
      .ac_nx (g2_ac),
      .hit   (g2_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grp_r  <= GRP_NONE;
         ir_r   <= '0;
         ac_r   <= '0;
         sw_r   <= '0;
         lk_r   <= 1'b0;
         pend   <= '0;
         busy   <= 1'b0;
         skip_r <= 1'b0;
         halt_r <= 1'b0;
         done_r <= 1'b0;
      end else begin
         done_r <= 1'b0;
         if (start && !busy) begin
            grp_r  <= grp_in;
            ir_r   <= instr[7:0];
            ac_r   <= ac_in;
            sw_r   <= sw_in;
            lk_r   <= link_in;
            pend   <= mask_in;
            busy   <= 1'b1;
            skip_r <= 1'b0;
            halt_r <= 1'b0;
         end else if (busy) begin
            case (grp_r)
               GRP_ONE: begin
                  ac_r <= g1_ac;
                  lk_r <= g1_lk;
               end
               GRP_TWO: begin
                  ac_r <= g2_ac;
                  if (first[0]) skip_r <= g2_hit;
               end
               default: ;
            endcase
            pend <= pend & ~first;
            if (last) begin
               busy   <= 1'b0;
               done_r <= 1'b1;
               halt_r <= (grp_r == GRP_TWO) && ir_r[1];
            end
         end
      end
   end

   assign ac_out   = ac_out_w();
   assign link_out = lk_r;
   assign skip_out = skip_r;
   assign halt_out = halt_r;
   assign done     = done_r;

   function automatic logic [DW-1:0] ac_out_w();
      return ac_r;
   endfunction

   // R10
   start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);

   // R10
   one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && pend != '0) |=> $countones(pend) == $past($countones(pend)) - 1);

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10
   hold_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(ac_out) && $stable(link_out) && $stable(skip_out)));

   // R11
   g2_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && grp_r == GRP_TWO) |=> $stable(link_out));

   // R1
   none_grp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && grp_r == GRP_NONE) |=> (done && $stable(ac_out) && !skip_out && !halt_out));

   // R9
   halt_grp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halt_out) |-> (done && grp_r == GRP_TWO));

endmodule

// File: tb/tb_opx_exec.sv
`timescale 1ns/100ps
module tb_opx_exec;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [11:0] instr = '0;
   logic [11:0] ac_in = '0;
   logic        link_in = 1'b0;
   logic [11:0] sw_in = '0;
   logic [11:0] ac_out;
   logic        link_out, skip_out, halt_out, done;

   int nchk = 0;
   int nerr = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   opx_exec dut (
      .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
      .ac_in(ac_in), .link_in(link_in), .sw_in(sw_in),
      .ac_out(ac_out), .link_out(link_out), .skip_out(skip_out),
      .halt_out(halt_out), .done(done)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic b(input logic [11:0] w, input int n);
      return w[11-n];
   endfunction

   // returns {cycles[3:0], link, ac[11:0]}
   function automatic logic [16:0] model_g1(input logic [11:0] w, input logic [11:0] a, input logic l);
      logic [12:0] v;
      int st = 0;
      int rots;
      if (b(w,4) || b(w,5)) st++;
      if (b(w,4)) a = '0;
      if (b(w,5)) l = 1'b0;
      if (b(w,6) || b(w,7)) st++;
      if (b(w,6)) a = ~a;
      if (b(w,7)) l = ~l;
      if (b(w,11)) begin
         st++;
         if (a == 12'hFFF) l = ~l;
         a = a + 12'd1;
      end
      if (b(w,8) || b(w,9)) st++;
      v = {l, a};
      rots = b(w,10) ? 2 : 1;
      for (int k = 0; k < rots; k++) begin
         if (b(w,8) && !b(w,9)) v = {v[0], v[12:1]};
         if (b(w,9) && !b(w,8)) v = {v[11:0], v[12]};
      end
      if (st == 0) st = 1;
      return {st[3:0], v};
   endfunction

   task automatic run(input logic [11:0] w, input logic [11:0] a, input logic l,
                      input logic [11:0] s, output int cyc);
      @(negedge clk);
      instr = w; ac_in = a; link_in = l; sw_in = s; start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      cyc = 0;
      do begin
         @(posedge clk);
         @(negedge clk);
         cyc++;
      end while (!done && cyc < 12);
   endtask

   task automatic hold_chk(input logic [11:0] a_exp);
      @(posedge clk);
      @(negedge clk);
      chk("R10 done pulse width", {31'd0, done}, 32'd0);
      chk("R10 ac held", {20'd0, ac_out}, {20'd0, a_exp});
   endtask

   logic [11:0] acs [0:4] = '{12'h000, 12'hFFF, 12'h800, 12'h5A3, 12'h7FF};

   initial begin
      int cyc;
      logic [16:0] m;
      logic [11:0] w, ea;
      logic t, esk;
      int est;

      repeat (3) @(negedge clk);
      // R2 reset values
      chk("R2 done", {31'd0, done}, 32'd0);
      chk("R2 skip", {31'd0, skip_out}, 32'd0);
      chk("R2 halt", {31'd0, halt_out}, 32'd0);
      chk("R2 link", {31'd0, link_out}, 32'd0);
      chk("R2 ac", {20'd0, ac_out}, 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 words outside both groups
      for (int op = 0; op < 8; op++) begin
         w = (op == 7) ? 12'hF01 : {op[2:0], 9'h1FF};
         run(w, 12'h5A3, 1'b1, 12'hFFF, cyc);
         chk("R1 ac unchanged", {20'd0, ac_out}, 32'h5A3);
         chk("R1 link unchanged", {31'd0, link_out}, 32'd1);
         chk("R1 skip low", {31'd0, skip_out}, 32'd0);
         chk("R1 halt low", {31'd0, halt_out}, 32'd0);
         chk("R1 R10 one step", cyc, 1);
      end

      // R4 directed: set link from either starting value
      run(12'hE50, 12'h123, 1'b0, 12'h000, cyc);
      chk("R4 set link from 0", {31'd0, link_out}, 32'd1);
      run(12'hE50, 12'h123, 1'b1, 12'h000, cyc);
      chk("R4 set link from 1", {31'd0, link_out}, 32'd1);
      // R6 directed: both rotate directions leave values alone
      run(12'hE0E, 12'h5A3, 1'b1, 12'h000, cyc);
      chk("R6 both dirs ac", {20'd0, ac_out}, 32'h5A3);
      chk("R6 both dirs link", {31'd0, link_out}, 32'd1);

      // group 1 full sweep of bits 4..11
      for (int i = 0; i < 256; i++) begin
         for (int ai = 0; ai < 4; ai++) begin
            for (int li = 0; li < 2; li++) begin
               w = {4'hE, i[7:0]};
               m = model_g1(w, acs[ai], li[0]);
               run(w, acs[ai], li[0], 12'hABC, cyc);
               chk("R3 R4 R5 R6 group1 ac", {20'd0, ac_out}, {20'd0, m[11:0]});
               chk("R3 R4 R5 R6 group1 link", {31'd0, link_out}, {31'd0, m[12]});
               chk("R10 group1 steps", cyc, {28'd0, m[16:13]});
               chk("R9 group1 no halt", {31'd0, halt_out}, 32'd0);
               hold_chk(m[11:0]);
            end
         end
      end

      // group 2 sweep of bits 4..10 with bit 11 clear
      for (int i = 0; i < 128; i++) begin
         for (int ai = 0; ai < 5; ai++) begin
            for (int li = 0; li < 2; li++) begin
               w = {4'hF, i[6:0], 1'b0};
               t = (b(w,5) && acs[ai][11]) || (b(w,6) && acs[ai] == 12'h000) ||
                   (b(w,7) && li[0]);
               esk = b(w,8) ? !t : t;
               ea = b(w,4) ? 12'h000 : acs[ai];
               if (b(w,9)) ea = ea | 12'h0C3;
               est = 1 + int'(b(w,4)) + int'(b(w,9));
               run(w, acs[ai], li[0], 12'h0C3, cyc);
               chk("R7 group2 skip", {31'd0, skip_out}, {31'd0, esk});
               chk("R8 group2 ac", {20'd0, ac_out}, {20'd0, ea});
               chk("R11 group2 link", {31'd0, link_out}, {31'd0, li[0]});
               chk("R9 group2 halt", {31'd0, halt_out}, {31'd0, b(w,10)});
               chk("R10 group2 steps", cyc, est);
               hold_chk(ea);
            end
         end
      end

      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         nchk++;
         nerr++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

endmodule